// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps one slot for each architectural register. A slot says whether a younger in-flight instruction will write that register and, if one will, which reorder buffer entry it holds. An out-of-order core uses it at issue to decide where each source operand comes from, and to record the new owner of the destination register.

Source lookups are combinational and follow the presented source indices in every cycle. `iss_valid` only qualifies the table update. Each source resolves to one of four outcomes. An unmapped register reads the register file. A mapped register whose value is on the writeback broadcast in this cycle takes that value. A mapped register whose entry is already done reads the reorder buffer. Any other mapped register returns its tag and waits. The read ports of the register file and the reorder buffer are outside this block: it drives their addresses and takes back their data.

The table changes only at issue, at commit and at flush. A writeback broadcast never alters it. Commit clears a slot only while that slot still names the retiring entry. A flush empties every slot.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register is unmapped, so every source reports origin code 0 (register file) with the register file value.
- R2: An issue with `iss_valid`=1 and `iss_dst_we`=1 maps `iss_dst_idx` to `iss_rob_tag` from the next cycle on, and a lookup of that register then reports that tag on `src_tag` and on `rob_raddr`.
- R3: A lookup of an unmapped register reports origin code 0, `src_ready`=1 and `src_value` equal to its `rf_rdata` lane.
- R4: A lookup of a mapped register whose `rob_rdone` lane is 1, with no matching broadcast, reports origin code 1, `src_ready`=1 and the `rob_rdata` lane as value.
- R5: A lookup of a mapped register whose tag equals `wb_tag` while `wb_valid`=1 reports origin code 2, `src_ready`=1 and `wb_data` as value. This takes priority over the reorder buffer path.
- R6: A lookup of a mapped register with no broadcast match and `rob_rdone`=0 reports origin code 3 and `src_ready`=0, with the tag on `src_tag`.
- R7: A writeback broadcast does not change any mapping. In a later cycle with no broadcast and `rob_rdone`=0, the register still reports code 3 and its tag.
- R8: Lookups in an issue cycle use the table as it was before that cycle's destination update, so a source equal to the destination sees the older tag.
- R9: A commit (`cmt_valid`=1) whose `cmt_rob_tag` equals the slot's tag for `cmt_dst_idx` unmaps that register from the next cycle on.
- R10: A commit whose tag differs from the slot's current tag leaves the mapping unchanged.
- R11: `flush`=1 unmaps every register from the next cycle on, and any issue or commit in the same cycle has no effect.
- R12: When an issue and a commit name the same register in one cycle, the issue's new mapping is kept.
- R13: An issue with `iss_dst_we`=0 changes no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clear all mappings (mispredict or exception) |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_we | input | 1 | Issuing instruction writes a destination register |
| iss_dst_idx | input | REG_W | Destination architectural register |
| iss_rob_tag | input | TAG_W | Reorder buffer entry allocated to the issuing instruction |
| iss_src_idx | input | NUM_SRC*REG_W | Source architectural registers, one lane per source |
| rf_raddr | output | NUM_SRC*REG_W | Register file read addresses |
| rf_rdata | input | NUM_SRC*DATA_W | Register file read data |
| rob_raddr | output | NUM_SRC*TAG_W | Reorder buffer read index (mapped tag) per source |
| rob_rdone | input | NUM_SRC | Addressed reorder buffer entry holds a finished result |
| rob_rdata | input | NUM_SRC*DATA_W | Addressed reorder buffer result |
| wb_valid | input | 1 | Writeback broadcast valid |
| wb_tag | input | TAG_W | Tag of the broadcast result |
| wb_data | input | DATA_W | Broadcast result value |
| cmt_valid | input | 1 | Head instruction with a destination commits |
| cmt_dst_idx | input | REG_W | Destination register of the committing instruction |
| cmt_rob_tag | input | TAG_W | Reorder buffer entry of the committing instruction |
| src_sel | output | NUM_SRC*2 | Origin per source: 0 register file, 1 reorder buffer, 2 broadcast, 3 wait |
| src_ready | output | NUM_SRC | Source value is available now |
| src_value | output | NUM_SRC*DATA_W | Source value when ready |
| src_tag | output | NUM_SRC*TAG_W | Mapped tag of the source register |

## Verification
The bench builds the block with eight architectural registers, an eight-entry reorder buffer, 16-bit data and two sources. With so few registers and tags, random issue, commit and broadcast traffic often hits the same register from both ports and often meets commits whose tag has gone stale. It also lines up broadcasts whose tag matches a live mapping. Directed cases then force each ordering of issue, commit and flush within one cycle.

// File: rtl/rst_pkg.sv
package rst_pkg;
    // Origin of a resolved source operand
    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_ROB   = 2'd1,
        SRC_BCAST = 2'd2,
        SRC_WAIT  = 2'd3
    } src_sel_e;
endpackage

// File: rtl/rst_map_table.sv
module rst_map_table #(
    parameter int NREGS = 32,
    parameter int TAG_W = 5,
    parameter int NRD   = 2,
    parameter int REG_W = $clog2(NREGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       set_en,
    input  logic [REG_W-1:0]           set_idx,
    input  logic [TAG_W-1:0]           set_tag,
    input  logic                       clr_en,
    input  logic [REG_W-1:0]           clr_idx,
    input  logic [TAG_W-1:0]           clr_tag,
    input  logic [NRD-1:0][REG_W-1:0]  rd_idx,
    output logic [NRD-1:0]             rd_busy,
    output logic [NRD-1:0][TAG_W-1:0]  rd_tag
);
    typedef struct packed {
        logic [NREGS-1:0]            busy;
        logic [NREGS-1:0][TAG_W-1:0] tag;
    } map_t;

    map_t map_d, map_q;

    // Next state: flush dominates; commit clears only a matching slot;
    // the issue write comes last so it overrides a same-register clear.
    always_comb begin
        map_d = map_q;
        if (flush) begin
            map_d.busy = '0;
        end else begin
            if (clr_en && map_q.busy[clr_idx] && (map_q.tag[clr_idx] == clr_tag)) begin
                map_d.busy[clr_idx] = 1'b0;
            end
            if (set_en) begin
                map_d.busy[set_idx] = 1'b1;
                map_d.tag[set_idx]  = set_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    // Read ports see registered state only (older mapping)
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_busy[g] = map_q.busy[rd_idx[g]];
        assign rd_tag[g]  = map_q.tag[rd_idx[g]];
    end
endmodule

// File: rtl/rst_src_resolve.sv
module rst_src_resolve #(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              busy,
    input  logic [TAG_W-1:0]  map_tag,
    input  logic [DATA_W-1:0] rf_data,
    input  logic              rob_done,
    input  logic [DATA_W-1:0] rob_data,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    output logic [1:0]        sel,
    output logic              ready,
    output logic [DATA_W-1:0] value
);
    import rst_pkg::*;

    src_sel_e sel_e;

    always_comb begin
        if (!busy) begin
            sel_e = SRC_RF;
            value = rf_data;
        end else if (wb_valid && (wb_tag == map_tag)) begin
            sel_e = SRC_BCAST;
            value = wb_data;
        end else if (rob_done) begin
            sel_e = SRC_ROB;
            value = rob_data;
        end else begin
            sel_e = SRC_WAIT;
            value = '0;
        end
    end

    assign sel   = sel_e;
    assign ready = (sel_e != SRC_WAIT);
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
    parameter int NREGS     = 32,
    parameter int ROB_DEPTH = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_SRC   = 2,
    localparam int REG_W    = $clog2(NREGS),
    localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          iss_valid,
    input  logic                          iss_dst_we,
    input  logic [REG_W-1:0]              iss_dst_idx,
    input  logic [TAG_W-1:0]              iss_rob_tag,
    input  logic [NUM_SRC-1:0][REG_W-1:0] iss_src_idx,
    output logic [NUM_SRC-1:0][REG_W-1:0] rf_raddr,
    input  logic [NUM_SRC-1:0][DATA_W-1:0] rf_rdata,
    output logic [NUM_SRC-1:0][TAG_W-1:0] rob_raddr,
    input  logic [NUM_SRC-1:0]            rob_rdone,
    input  logic [NUM_SRC-1:0][DATA_W-1:0] rob_rdata,
    input  logic                          wb_valid,
    input  logic [TAG_W-1:0]              wb_tag,
    input  logic [DATA_W-1:0]             wb_data,
    input  logic                          cmt_valid,
    input  logic [REG_W-1:0]              cmt_dst_idx,
    input  logic [TAG_W-1:0]              cmt_rob_tag,
    output logic [NUM_SRC-1:0][1:0]       src_sel,
    output logic [NUM_SRC-1:0]            src_ready,
    output logic [NUM_SRC-1:0][DATA_W-1:0] src_value,
    output logic [NUM_SRC-1:0][TAG_W-1:0] src_tag
);
    logic [NUM_SRC-1:0]            map_busy;
    logic [NUM_SRC-1:0][TAG_W-1:0] map_tag;

    rst_map_table #(
        .NREGS (NREGS),
        .TAG_W (TAG_W),
        .NRD   (NUM_SRC),
        .REG_W (REG_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .set_en  (iss_valid && iss_dst_we),
        .set_idx (iss_dst_idx),
        .set_tag (iss_rob_tag),
        .clr_en  (cmt_valid),
        .clr_idx (cmt_dst_idx),
        .clr_tag (cmt_rob_tag),
        .rd_idx  (iss_src_idx),
        .rd_busy (map_busy),
        .rd_tag  (map_tag)
    );

    assign rf_raddr  = iss_src_idx;
    assign rob_raddr = map_tag;
    assign src_tag   = map_tag;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        rst_src_resolve #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) u_res (
            .busy     (map_busy[g]),
            .map_tag  (map_tag[g]),
            .rf_data  (rf_rdata[g]),
            .rob_done (rob_rdone[g]),
            .rob_data (rob_rdata[g]),
            .wb_valid (wb_valid),
            .wb_tag   (wb_tag),
            .wb_data  (wb_data),
            .sel      (src_sel[g]),
            .ready    (src_ready[g]),
            .value    (src_value[g])
        );
    end
endmodule

// File: rtl/rst_chk.sv
module rst_chk #(
    parameter int NREGS     = 32,
    parameter int ROB_DEPTH = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_SRC   = 2,
    localparam int REG_W    = $clog2(NREGS),
    localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          flush,
    input logic                          iss_valid,
    input logic                          iss_dst_we,
    input logic [REG_W-1:0]              iss_dst_idx,
    input logic [TAG_W-1:0]              iss_rob_tag,
    input logic [NUM_SRC-1:0][REG_W-1:0] iss_src_idx,
    input logic [NUM_SRC-1:0][DATA_W-1:0] rf_rdata,
    input logic [NUM_SRC-1:0][TAG_W-1:0] rob_raddr,
    input logic [NUM_SRC-1:0]            rob_rdone,
    input logic [NUM_SRC-1:0][DATA_W-1:0] rob_rdata,
    input logic                          wb_valid,
    input logic [TAG_W-1:0]              wb_tag,
    input logic [DATA_W-1:0]             wb_data,
    input logic [NUM_SRC-1:0][1:0]       src_sel,
    input logic [NUM_SRC-1:0]            src_ready,
    input logic [NUM_SRC-1:0][DATA_W-1:0] src_value,
    input logic [NUM_SRC-1:0][TAG_W-1:0] src_tag
);
    import rst_pkg::*;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        // R3
        rf_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel[g] == SRC_RF) |-> (src_ready[g] && src_value[g] == rf_rdata[g]));

        // R4
        rob_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel[g] == SRC_ROB) |-> (rob_rdone[g] && src_value[g] == rob_rdata[g]
                                         && rob_raddr[g] == src_tag[g]));

        // R5
        bcast_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel[g] == SRC_BCAST) |-> (wb_valid && wb_tag == src_tag[g]
                                           && src_value[g] == wb_data));

        // R6
        wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel[g] == SRC_WAIT) |-> !src_ready[g]);

        // R11
        flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(flush) |-> (src_sel[g] == SRC_RF));

        // R2
        issue_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(iss_valid && iss_dst_we && !flush) && iss_src_idx[g] == $past(iss_dst_idx))
            |-> (src_tag[g] == $past(iss_rob_tag) && src_sel[g] != SRC_RF));
    end
endmodule

bind rename_status_table rst_chk #(
    .NREGS     (NREGS),
    .ROB_DEPTH (ROB_DEPTH),
    .DATA_W    (DATA_W),
    .NUM_SRC   (NUM_SRC)
) u_chk (.*);

// File: tb/rename_status_table_bench.sv
module rename_status_table_bench;
    localparam int NREGS = 8, ROB_DEPTH = 8, DATA_W = 16, NUM_SRC = 2;
    localparam int REG_W = $clog2(NREGS), TAG_W = $clog2(ROB_DEPTH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic flush, iss_valid, iss_dst_we, wb_valid, cmt_valid;
    logic [REG_W-1:0] iss_dst_idx, cmt_dst_idx;
    logic [TAG_W-1:0] iss_rob_tag, wb_tag, cmt_rob_tag;
    logic [DATA_W-1:0] wb_data;
    logic [NUM_SRC-1:0][REG_W-1:0]  iss_src_idx, rf_raddr;
    logic [NUM_SRC-1:0][DATA_W-1:0] rf_rdata, rob_rdata, src_value;
    logic [NUM_SRC-1:0][TAG_W-1:0]  rob_raddr, src_tag;
    logic [NUM_SRC-1:0]             rob_rdone, src_ready;
    logic [NUM_SRC-1:0][1:0]        src_sel;

    int checks = 0, failures = 0;
    logic             m_busy [NREGS];
    logic [TAG_W-1:0] m_tag  [NREGS];

    always #4 clk = ~clk;   // 125 MHz

    rename_status_table #(.NREGS(NREGS), .ROB_DEPTH(ROB_DEPTH), .DATA_W(DATA_W),
                          .NUM_SRC(NUM_SRC)) u_rename_status_table (.*);

    function automatic logic [1:0] exp_sel(input int s);
        int r = iss_src_idx[s];
        if (!m_busy[r]) return 2'd0;
        if (wb_valid && wb_tag == m_tag[r]) return 2'd2;
        if (rob_rdone[s]) return 2'd1;
        return 2'd3;
    endfunction

    function automatic logic [DATA_W-1:0] exp_val(input int s, input logic [1:0] sel);
        case (sel)
            2'd0: return rf_rdata[s];
            2'd1: return rob_rdata[s];
            2'd2: return wb_data;
            default: return '0;
        endcase
    endfunction

    task automatic idle();
        flush = 0; iss_valid = 0; iss_dst_we = 0; wb_valid = 0; cmt_valid = 0;
        iss_dst_idx = '0; cmt_dst_idx = '0; iss_rob_tag = '0; wb_tag = '0; cmt_rob_tag = '0;
        wb_data = $urandom; rob_rdone = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            iss_src_idx[s] = '0; rf_rdata[s] = $urandom; rob_rdata[s] = $urandom;
        end
    endtask

    // Inputs set just after a falling edge; check, update model, advance one cycle
    task automatic step(input string req);
        #1;
        for (int s = 0; s < NUM_SRC; s++) begin
            logic [1:0] es = exp_sel(s);
            int r = iss_src_idx[s];
            logic bad = (src_sel[s] !== es) || (src_ready[s] !== (es != 2'd3));
            if (es != 2'd3 && src_value[s] !== exp_val(s, es)) bad = 1;
            if (m_busy[r] && src_tag[s] !== m_tag[r]) bad = 1;
            if (rf_raddr[s] !== iss_src_idx[s]) bad = 1;
            checks++;
            if (bad) begin
                failures++;
                $display("FAIL %s src%0d reg%0d: sel=%0d val=%h tag=%0d expected sel=%0d val=%h tag=%0d",
                         req, s, r, src_sel[s], src_value[s], src_tag[s], es, exp_val(s, es), m_tag[r]);
            end
        end
        if (flush) begin
            for (int r = 0; r < NREGS; r++) m_busy[r] = 0;
        end else begin
            if (cmt_valid && m_busy[cmt_dst_idx] && m_tag[cmt_dst_idx] == cmt_rob_tag)
                m_busy[cmt_dst_idx] = 0;
            if (iss_valid && iss_dst_we) begin
                m_busy[iss_dst_idx] = 1; m_tag[iss_dst_idx] = iss_rob_tag;
            end
        end
        @(posedge clk); @(negedge clk);
        idle();
    endtask

    task automatic look(input int r0, input int r1, input logic [1:0] done, input string req);
        iss_src_idx[0] = REG_W'(r0); iss_src_idx[1] = REG_W'(r1); rob_rdone = done;
        step(req);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREGS; r++) begin m_busy[r] = 0; m_tag[r] = '0; end
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state, every register reads the register file
        for (int r = 0; r < NREGS; r++) look(r, NREGS - 1 - r, 2'b11, "R1");
        // R3: unmapped register reads register file
        look(7, 0, 2'b00, "R3");
        // R2: map r2 -> tag 4
        iss_valid = 1; iss_dst_we = 1; iss_dst_idx = 2; iss_rob_tag = 4; step("R2");
        look(2, 2, 2'b10, "R2");
        // R6: not done, no broadcast -> wait
        look(2, 0, 2'b00, "R6");
        // R4: done in the reorder buffer
        look(2, 2, 2'b11, "R4");
        // R5: broadcast match beats reorder buffer
        wb_valid = 1; wb_tag = 4; look(2, 2, 2'b01, "R5");
        // R7: broadcast left the mapping in place
        look(2, 2, 2'b00, "R7");
        // R8: source equals destination, sees older tag 4 while r2 -> tag 5
        iss_valid = 1; iss_dst_we = 1; iss_dst_idx = 2; iss_rob_tag = 5; look(2, 2, 2'b00, "R8");
        // R10: stale commit of tag 4 leaves r2 -> 5
        cmt_valid = 1; cmt_dst_idx = 2; cmt_rob_tag = 4; look(2, 1, 2'b00, "R10");
        look(2, 2, 2'b00, "R10");
        // R9: matching commit unmaps r2
        cmt_valid = 1; cmt_dst_idx = 2; cmt_rob_tag = 5; look(2, 1, 2'b00, "R9");
        look(2, 2, 2'b00, "R9");
        // R12: same-cycle issue and commit on r1, issue wins
        iss_valid = 1; iss_dst_we = 1; iss_dst_idx = 1; iss_rob_tag = 2; step("R12");
        iss_valid = 1; iss_dst_we = 1; iss_dst_idx = 1; iss_rob_tag = 3;
        cmt_valid = 1; cmt_dst_idx = 1; cmt_rob_tag = 2; look(1, 1, 2'b00, "R12");
        look(1, 1, 2'b00, "R12");
        // R13: no destination write -> no mapping
        iss_valid = 1; iss_dst_we = 0; iss_dst_idx = 5; iss_rob_tag = 1; step("R13");
        look(5, 5, 2'b00, "R13");
        // R11: flush clears all and drops a same-cycle issue
        iss_valid = 1; iss_dst_we = 1; iss_dst_idx = 3; iss_rob_tag = 6; step("R11");
        flush = 1; iss_valid = 1; iss_dst_we = 1; iss_dst_idx = 6; iss_rob_tag = 7; step("R11");
        look(3, 6, 2'b00, "R11");
        look(1, 0, 2'b00, "R11");

        // Random traffic covering R2 R4 R5 R6 R9 R10 R12 together
        for (int i = 0; i < 4000; i++) begin
            iss_valid   = ($urandom_range(0, 2) != 0);
            iss_dst_we  = ($urandom_range(0, 3) != 0);
            iss_dst_idx = REG_W'($urandom); iss_rob_tag = TAG_W'($urandom);
            for (int s = 0; s < NUM_SRC; s++) iss_src_idx[s] = REG_W'($urandom);
            rob_rdone = NUM_SRC'($urandom);
            wb_valid  = ($urandom_range(0, 2) == 0); wb_tag = TAG_W'($urandom);
            cmt_valid = ($urandom_range(0, 2) == 0); cmt_dst_idx = REG_W'($urandom);
            cmt_rob_tag = ($urandom_range(0, 1) == 0) ? m_tag[cmt_dst_idx] : TAG_W'($urandom);
            flush = ($urandom_range(0, 39) == 0);
            step("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule